// File: doc/BRIEF.md
# Redundant Boot Device Fail-Over Controller

This block supervises start-up from two boot memories that sit in one shared address window. The processor sees a single range; the block decides which of two chip-select outputs answers an access. After power-up or any externally caused reset the first (primary) device serves the window. Firmware must then service a watchdog within a programmable number of base periods. The base period is a parameter in clock cycles, nominally 1.6 s.

A missed watchdog resets the system and moves the boot to the other device. The order of attempts is fixed: primary, secondary, then primary once more. A third miss leaves the processor halted in reset until an external reset source fires. Firmware marks a good boot by writing a boot-complete register. That write rewinds the attempt count but leaves the record of earlier failures, which software can read from a status byte.

Six reset inputs are merged into one stretched system reset: power-on, software request, push-button, debug port, supervisor and power-fail. The watchdog expiry and the halt state feed the same reset. A copy of the reset goes to the backplane only when the board sits in the system slot.

Top module: `boot_failover_ctrl`

## Requirements
- R1: After power-on reset or any pulse on an external reset input, the attempt number is 0 and the primary device is active. A power-on reset also clears the failure history, the done flag and the halt; the other external inputs clear the halt and the done flag but keep the history.
- R2: An accepted boot-window access raises exactly one chip select one cycle later: `cs_secondary` when the attempt number is 1, `cs_primary` otherwise. No chip select is raised without an access or while `sys_rst` is high.
- R3: The watchdog expires max(M,1)×BASE_CYC cycles after the last kick or the end of system reset, where M is the multiplier register. M returns to DEF_MULT on every system reset.
- R4: On an expiry, the bit of the current attempt is set in the history and the attempt number advances 0→1→2, with a system reset. Attempt 1 uses the secondary device; attempt 2 uses the primary again.
- R5: An expiry during attempt 2 sets `halted`. `halted` and `sys_rst` then stay high until an external reset input is asserted.
- R6: `status` is registered one cycle behind the state. Bits [1:0] hold the attempt number, bit 2 is 1 when the secondary is active, bits [5:3] hold the failure history (bit 3+n for attempt n), bit 6 is the OR of the history, and bit 7 is the boot-complete flag.
- R7: Any reset input, a watchdog expiry or the halt state drives `sys_rst` high at the next edge. `sys_rst` falls HOLD_CYC+1 cycles after the last cycle in which a source was present.
- R8: Reads of size 0 (8-bit), 1 (16-bit) or 2 (32-bit) are accepted; writes only of size 1. A refused access raises `bus_err` for one cycle, one cycle later, and raises no chip select.
- R9: `bp_rst` follows the system reset only while `system_slot` is high; otherwise it stays low.
- R10: Writing address 2 (boot complete) sets the done flag and returns the attempt number to 0 while keeping the history. A later expiry therefore selects the secondary again.
- R11: Register writes (address 0 kick, 1 multiplier, 2 boot complete) are ignored while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| sw_rst_req | input | 1 | Software reset request |
| btn_rst | input | 1 | Push-button reset |
| jtag_rst | input | 1 | Debug-port reset |
| sup_rst | input | 1 | Supervisor circuit reset |
| pwr_fail | input | 1 | Power-fail warning |
| system_slot | input | 1 | Board sits in the system slot |
| bus_req | input | 1 | Access to the shared boot window this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 2 | 0 kick, 1 multiplier, 2 boot complete |
| reg_wdata | input | 8 | Write data (multiplier uses the low MULT_W bits) |
| cs_primary | output | 1 | Chip select of the primary device |
| cs_secondary | output | 1 | Chip select of the secondary device |
| bus_err | output | 1 | Refused access |
| sys_rst | output | 1 | Stretched system reset |
| bp_rst | output | 1 | Backplane reset |
| halted | output | 1 | Retry sequence exhausted |
| status | output | 8 | Boot status byte |

## Verification
The bench builds the block with BASE_CYC = 20, DEF_MULT = 2 and HOLD_CYC = 4. With these values a default timeout is 40 cycles and a multiplier of 1 gives 20, so the whole three-attempt sequence fits in a few hundred cycles. That reach covers the halt, a recovery by push-button, and a boot-complete followed by a fresh failure. The short hold lets every reset source and both slot settings be pulsed, and each release time measured exactly.

// File: rtl/boot_fo_pkg.sv
package boot_fo_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RA_KICK = 2'd0,
    RA_MULT = 2'd1,
    RA_DONE = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ATT_FIRST  = 2'd0,
    ATT_SECOND = 2'd1,
    ATT_THIRD  = 2'd2,
    ATT_UNUSED = 2'd3
  } attempt_e;

  localparam int unsigned NUM_RST_SRC = 7;
endpackage

// File: rtl/bfo_wdog.sv
module bfo_wdog #(
  parameter int unsigned BASE_CYC = 80_000_000,
  parameter int unsigned MULT_W   = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              kick,
  input  logic [MULT_W-1:0] mult,
  output logic              expire
);
  localparam int unsigned SUB_W = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BASE_CYC - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [MULT_W-1:0] per_q;
  logic [MULT_W-1:0] eff_mult;
  logic              sub_end;
  logic              per_end;

  always_comb begin
    eff_mult = (mult == '0) ? MULT_W'(1) : mult;
    sub_end  = (sub_q == SUB_LAST);
    per_end  = (per_q >= eff_mult - MULT_W'(1));
    expire   = !clr && !kick && sub_end && per_end;
  end

  always_ff @(posedge clk) begin
    if (clr || kick) begin
      sub_q <= '0;
      per_q <= '0;
    end else if (sub_end) begin
      sub_q <= '0;
      per_q <= per_end ? '0 : per_q + MULT_W'(1);
    end else begin
      sub_q <= sub_q + SUB_W'(1);
    end
  end
endmodule

// File: rtl/bfo_rst_stretch.sv
module bfo_rst_stretch #(
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned NSRC     = 7
) (
  input  logic            clk,
  input  logic [NSRC-1:0] src,
  input  logic            slot,
  output logic            sys_rst,
  output logic            bp_rst
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          any_src;
  logic          rst_next;

  always_comb begin
    any_src  = |src;
    rst_next = any_src || (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (any_src)             cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    sys_rst <= rst_next;
    bp_rst  <= rst_next && slot;
  end
endmodule

// File: rtl/bfo_sequencer.sv
module bfo_sequencer
  import boot_fo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_rst,
  input  logic       wd_expire,
  input  logic       done_wr,
  output attempt_e   attempt,
  output logic [2:0] hist,
  output logic       halt,
  output logic       done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      attempt <= ATT_FIRST;
      hist    <= '0;
      halt    <= 1'b0;
      done    <= 1'b0;
    end else if (ext_rst) begin
      attempt <= ATT_FIRST;
      halt    <= 1'b0;
      done    <= 1'b0;
    end else if (wd_expire) begin
      hist <= hist | (3'b001 << attempt);
      done <= 1'b0;
      case (attempt)
        ATT_FIRST:  attempt <= ATT_SECOND;
        ATT_SECOND: attempt <= ATT_THIRD;
        default:    halt    <= 1'b1;
      endcase
    end else if (done_wr) begin
      attempt <= ATT_FIRST;
      done    <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_failover_ctrl.sv
module boot_failover_ctrl
  import boot_fo_pkg::*;
#(
  parameter int unsigned BASE_CYC = 80_000_000,
  parameter int unsigned MULT_W   = 4,
  parameter int unsigned DEF_MULT = 2,
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_rst_req,
  input  logic       btn_rst,
  input  logic       jtag_rst,
  input  logic       sup_rst,
  input  logic       pwr_fail,
  input  logic       system_slot,
  input  logic       bus_req,
  input  logic       bus_wr,
  input  logic [1:0] bus_size,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       cs_primary,
  output logic       cs_secondary,
  output logic       bus_err,
  output logic       sys_rst,
  output logic       bp_rst,
  output logic       halted,
  output logic [7:0] status
);
  localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(DEF_MULT);

  logic              ext_rst;
  logic              wr_ok;
  logic              kick;
  logic              mult_wr;
  logic              done_wr;
  logic              wd_expire;
  logic              acc_ok;
  logic [MULT_W-1:0] mult_q;
  logic [NUM_RST_SRC-1:0] src_vec;
  attempt_e          attempt;
  logic [2:0]        hist;
  logic              halt;
  logic              done;

  always_comb begin
    ext_rst = rst | sw_rst_req | btn_rst | jtag_rst | sup_rst | pwr_fail;
    wr_ok   = reg_wr && !sys_rst;
    kick    = wr_ok && (reg_addr == RA_KICK);
    mult_wr = wr_ok && (reg_addr == RA_MULT);
    done_wr = wr_ok && (reg_addr == RA_DONE);
    if (bus_wr) acc_ok = (bus_size == SZ_HALF);
    else        acc_ok = (bus_size != SZ_RSVD);
    src_vec = {ext_rst, wd_expire, halt, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (rst || sys_rst)  mult_q <= MULT_RST;
    else if (mult_wr)    mult_q <= reg_wdata[MULT_W-1:0];
  end

  bfo_wdog #(
    .BASE_CYC (BASE_CYC),
    .MULT_W   (MULT_W)
  ) u_wdog (
    .clk    (clk),
    .clr    (rst | sys_rst),
    .kick   (kick),
    .mult   (mult_q),
    .expire (wd_expire)
  );

  bfo_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .ext_rst   (ext_rst),
    .wd_expire (wd_expire),
    .done_wr   (done_wr),
    .attempt   (attempt),
    .hist      (hist),
    .halt      (halt),
    .done      (done)
  );

  bfo_rst_stretch #(
    .HOLD_CYC (HOLD_CYC),
    .NSRC     (NUM_RST_SRC)
  ) u_rst (
    .clk     (clk),
    .src     (src_vec),
    .slot    (system_slot),
    .sys_rst (sys_rst),
    .bp_rst  (bp_rst)
  );

  assign halted = halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_primary   <= 1'b0;
      cs_secondary <= 1'b0;
      bus_err      <= 1'b0;
      status       <= '0;
    end else begin
      cs_primary   <= bus_req && acc_ok && !sys_rst && (attempt != ATT_SECOND);
      cs_secondary <= bus_req && acc_ok && !sys_rst && (attempt == ATT_SECOND);
      bus_err      <= bus_req && !acc_ok && !sys_rst;
      status       <= {done, |hist, hist, attempt == ATT_SECOND, attempt};
    end
  end
endmodule

// File: rtl/bfo_checker.sv
module bfo_checker (
  input logic       clk,
  input logic       rst,
  input logic       sw_rst_req,
  input logic       btn_rst,
  input logic       jtag_rst,
  input logic       sup_rst,
  input logic       pwr_fail,
  input logic       system_slot,
  input logic       bus_req,
  input logic       bus_wr,
  input logic [1:0] bus_size,
  input logic       cs_primary,
  input logic       cs_secondary,
  input logic       sys_rst,
  input logic       bp_rst,
  input logic       halted,
  input logic [7:0] status
);
  logic ext_any;
  assign ext_any = sw_rst_req | btn_rst | jtag_rst | sup_rst | pwr_fail;

  p_one_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !(cs_primary && cs_secondary));

  p_no_cs_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !(cs_primary || cs_secondary));

  p_idle_no_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !(cs_primary || cs_secondary));

  p_ext_resets_r7: assert property (@(posedge clk) disable iff (rst)
    ext_any |=> sys_rst);

  p_write_size_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_size != 2'd1) |=> !(cs_primary || cs_secondary));

  p_backplane_slot_r9: assert property (@(posedge clk) disable iff (rst)
    bp_rst |-> $past(system_slot));

  p_halt_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (halted && !ext_any) |=> (halted && sys_rst));

  p_primary_after_ext_r1: assert property (@(posedge clk) disable iff (rst)
    $past(ext_any) |=> (status[2:0] == 3'b000));

  p_sec_flag_r6: assert property (@(posedge clk) disable iff (rst)
    status[2] == (status[1:0] == 2'd1));
endmodule

bind boot_failover_ctrl bfo_checker u_bfo_checker (
  .clk          (clk),
  .rst          (rst),
  .sw_rst_req   (sw_rst_req),
  .btn_rst      (btn_rst),
  .jtag_rst     (jtag_rst),
  .sup_rst      (sup_rst),
  .pwr_fail     (pwr_fail),
  .system_slot  (system_slot),
  .bus_req      (bus_req),
  .bus_wr       (bus_wr),
  .bus_size     (bus_size),
  .cs_primary   (cs_primary),
  .cs_secondary (cs_secondary),
  .sys_rst      (sys_rst),
  .bp_rst       (bp_rst),
  .halted       (halted),
  .status       (status)
);

// File: tb/boot_failover_ctrl_bench.sv
`timescale 1ns/1ps
module boot_failover_ctrl_bench;
  localparam int B    = 20;
  localparam int MW   = 4;
  localparam int DEFM = 2;
  localparam int H    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rst_req = 0, btn_rst = 0, jtag_rst = 0, sup_rst = 0, pwr_fail = 0;
  logic system_slot = 0;
  logic bus_req = 0, bus_wr = 0;
  logic [1:0] bus_size = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic cs_primary, cs_secondary, bus_err, sys_rst, bp_rst, halted;
  logic [7:0] status;

  always #10 clk = ~clk;

  boot_failover_ctrl #(.BASE_CYC(B), .MULT_W(MW), .DEF_MULT(DEFM), .HOLD_CYC(H)) u_boot_failover_ctrl (
    .clk(clk), .rst(rst), .sw_rst_req(sw_rst_req), .btn_rst(btn_rst), .jtag_rst(jtag_rst),
    .sup_rst(sup_rst), .pwr_fail(pwr_fail), .system_slot(system_slot), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_size(bus_size), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cs_primary(cs_primary), .cs_secondary(cs_secondary),
    .bus_err(bus_err), .sys_rst(sys_rst), .bp_rst(bp_rst), .halted(halted), .status(status));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model: one elapsed-time integer, attempt/history integers
  int m_rst = 1, m_cnt = 0, m_att = 0, m_hist = 0, m_halt = 0, m_done = 0;
  int m_mult = DEFM, m_el = 0;
  int m_csp = 0, m_css = 0, m_berr = 0, m_bp = 0, m_status = 0;
  int ext, wok, kick, mw, dn, eff, expv, src, accok, old_status;

  always @(posedge clk) begin
    ext  = rst | sw_rst_req | btn_rst | jtag_rst | sup_rst | pwr_fail;
    wok  = reg_wr && !m_rst;
    kick = wok && reg_addr == 0;
    mw   = wok && reg_addr == 1;
    dn   = wok && reg_addr == 2;
    eff  = (m_mult == 0) ? 1 : m_mult;
    expv = !rst && !m_rst && !kick && (m_el >= eff * B - 1) && ((m_el % B) == B - 1);
    src  = ext || expv || m_halt;
    accok = bus_req && (bus_wr ? (bus_size == 1) : (bus_size != 3));
    old_status = (m_done << 7) | ((m_hist != 0) << 6) | (m_hist << 3) | ((m_att == 1) << 2) | m_att;
    if (rst) begin
      m_csp = 0; m_css = 0; m_berr = 0; m_status = 0;
    end else begin
      m_csp  = accok && !m_rst && m_att != 1;
      m_css  = accok && !m_rst && m_att == 1;
      m_berr = bus_req && !accok && !m_rst;
      m_status = old_status;
    end
    if (rst || m_rst) m_mult = DEFM;
    else if (mw) m_mult = reg_wdata % (1 << MW);
    if (rst || m_rst || kick || expv) m_el = 0; else m_el = m_el + 1;
    if (rst) begin m_att = 0; m_hist = 0; m_halt = 0; m_done = 0; end
    else if (ext) begin m_att = 0; m_halt = 0; m_done = 0; end
    else if (expv) begin
      m_hist = m_hist | (1 << m_att); m_done = 0;
      if (m_att == 2) m_halt = 1; else m_att = m_att + 1;
    end else if (dn) begin m_att = 0; m_done = 1; end
    m_rst = src || (m_cnt != 0);
    m_cnt = src ? H : ((m_cnt != 0) ? m_cnt - 1 : 0);
    m_bp  = m_rst && system_slot;
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R7 sys_rst", sys_rst, m_rst);
      chk("R2 cs_primary", cs_primary, m_csp);
      chk("R2 cs_secondary", cs_secondary, m_css);
      chk("R8 bus_err", bus_err, m_berr);
      chk("R9 bp_rst", bp_rst, m_bp);
      chk("R5 halted", halted, m_halt);
      chk("R6 status", status, m_status);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic access(logic wr, logic [1:0] sz);
    bus_req = 1; bus_wr = wr; bus_size = sz;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic pulse(int i);
    case (i)
      0: sw_rst_req = 1;
      1: btn_rst = 1;
      2: jtag_rst = 1;
      3: sup_rst = 1;
      default: pwr_fail = 1;
    endcase
    @(negedge clk);
    sw_rst_req = 0; btn_rst = 0; jtag_rst = 0; sup_rst = 0; pwr_fail = 0;
  endtask

  task automatic wait_rise();
    while (!sys_rst) @(negedge clk);
  endtask

  task automatic wait_fall();
    while (sys_rst) @(negedge clk);
  endtask

  initial begin
    int n;
    tick(3);
    rst = 0;
    wait_fall();
    tick(2);
    chk("R1 status after power-on", status, 8'h00);
    wreg(0, 0);
    access(0, 0);
    chk("R2 byte read primary", {cs_primary, cs_secondary}, 2'b10);
    access(0, 2);
    chk("R2 word read primary", {cs_primary, cs_secondary}, 2'b10);
    access(1, 1);
    chk("R8 half write accepted", {cs_primary, bus_err}, 2'b10);
    access(1, 2);
    chk("R8 word write refused", {cs_primary, cs_secondary, bus_err}, 3'b001);
    access(1, 0);
    chk("R8 byte write refused", {cs_primary, cs_secondary, bus_err}, 3'b001);
    // R3 default timeout
    wreg(0, 0);
    n = 0;
    while (!sys_rst) begin @(negedge clk); n++; end
    chk("R3 default timeout", n, DEFM * B);
    wait_fall(); tick(2);
    chk("R4 first failure to secondary", status[3:0], 4'b1101);
    access(0, 1);
    chk("R2 secondary read", {cs_primary, cs_secondary}, 2'b01);
    // R3 programmed multiplier
    wreg(1, 1);
    wreg(0, 0);
    n = 0;
    while (!sys_rst) begin @(negedge clk); n++; end
    chk("R3 multiplier one", n, B);
    wait_fall(); tick(2);
    chk("R4 second failure to primary", status[2:0], 3'b010);
    access(0, 0);
    chk("R4 primary again", {cs_primary, cs_secondary}, 2'b10);
    // third failure halts
    wait_rise(); tick(20);
    chk("R5 halted", {halted, sys_rst}, 2'b11);
    wreg(0, 0);
    wreg(2, 0);
    tick(5);
    chk("R11 write ignored in reset", {halted, sys_rst, status[7]}, 3'b110);
    chk("R6 full history", status[6:3], 4'b1111);
    pulse(1);
    wait_fall(); tick(2);
    chk("R1 button restart keeps history", {halted, status[6], status[2:0]}, 5'b01000);
    // R10 boot complete
    wait_rise(); wait_fall(); tick(2);
    chk("R10 pre-done attempt", status[1:0], 2'd1);
    wreg(2, 0);
    tick(2);
    chk("R10 done clears attempt", {status[7], status[6], status[1:0]}, 4'b1100);
    wait_rise(); wait_fall(); tick(2);
    chk("R10 later failure to secondary", {status[7], status[2:0]}, 4'b0101);
    // reset sources and stretch
    system_slot = 1;
    for (int i = 0; i < 5; i++) begin
      tick(3);
      pulse(i);
      chk("R7 source asserts reset", sys_rst, 1);
      chk("R9 slot passes reset", bp_rst, 1);
      n = 0;
      while (sys_rst) begin @(negedge clk); n++; end
      chk("R7 hold length", n, H + 1);
    end
    system_slot = 0;
    tick(3);
    pulse(4);
    chk("R9 no backplane reset off slot", {sys_rst, bp_rst}, 2'b10);
    wait_fall(); tick(2);
    chk("R1 power-fail returns to primary", status[2:0], 3'b000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule